// File: doc/BRIEF.md
# Shared-Bus Dual-Channel ADC Capture Sequencer

This block takes a serial peripheral bus that is shared with several other devices. It first programs a two-channel programmable-gain amplifier and then reads both results of a dual-channel 14-bit converter. All the other devices on the bus are kept silent by holding each of their select or enable lines at its own inactive level. For a capture, the block shifts an 8-bit gain word into the amplifier and releases the amplifier select. It then raises a conversion strobe, which makes the converter sample both analog inputs at the same instant. After that it clocks in a read frame and pulls the two channel fields out of it.

A one-cycle `start` pulse begins a capture. The two gain codes are taken at that moment. When the frame is complete, `done` pulses for one cycle and both signed samples update together. Any `start` that arrives during a capture has no effect. The serial clock comes from dividing the system clock, so its half period is a parameter that can be set to suit the slowest device on the bus. Turning the samples into volts or speed is left to downstream logic. For reference, the converter outputs code = GAIN × (Vin − 1.65 V) / 1.25 V × 8192, clamped to 14 bits.

Top module: `adc_capture_seq`

## Requirements
- R1: After reset, and whenever the block is idle, `sck` is 0, `amp_cs_n` is 1, `adc_conv` is 0, `busy` and `done` are 0, and after reset both samples read 0.
- R2: `flash_ss_n`, `dac_cs_n`, `pflash_ce` and `prom_init_n` are held at 1 at all times.
- R3: During the gain phase, `amp_cs_n` is 0 and exactly 8 rising `sck` edges occur. `mosi` carries the word {gain_b[3:0], gain_a[3:0]} MSB first. It changes only on falling edges, so each bit is stable at its rising edge.
- R4: `amp_cs_n` returns to 1, and CS_GAP_CLKS cycles later `adc_conv` rises. It stays high for CONV_CLKS cycles while `sck` is 0. `adc_conv` is never 1 while `amp_cs_n` is 0.
- R5: The read frame has LEAD_BITS + 2×14 + MID_BITS + TRAIL_BITS rising `sck` edges (34 by default). `miso` is sampled at each rising edge. With bit positions counted from 0 in arrival order, bits 2..15 form channel A and bits 18..31 form channel B, each sent MSB first. Bits 0, 1, 16, 17, 32 and 33 have no effect on the results.
- R6: `done` is a single-cycle pulse. It occurs in the cycle after the last falling `sck` edge of the read frame. `sample_a` and `sample_b` take their new two's-complement values in that same cycle and hold them at all other times.
- R7: A `start` while idle makes `busy` 1 in the next cycle. `busy` stays 1 until the cycle of `done`. A `start` while busy has no effect: it produces no extra `done` and no extra bus activity.
- R8: Successive rising `sck` edges within a phase are 2×HALF_DIV system clock cycles apart.
- R9: The gain codes are captured at the accepted `start`. Changes on `gain_a` or `gain_b` after that do not alter the word that is shifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a capture (ignored while busy) |
| gain_a | input | 4 | Gain code for channel A |
| gain_b | input | 4 | Gain code for channel B |
| miso | input | 1 | Serial data from converter |
| sck | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to amplifier |
| amp_cs_n | output | 1 | Amplifier select, active low |
| adc_conv | output | 1 | Conversion strobe, active high |
| flash_ss_n | output | 1 | Serial flash select, held inactive (1) |
| dac_cs_n | output | 1 | DAC select, held inactive (1) |
| pflash_ce | output | 1 | Parallel flash enable, held inactive (1) |
| prom_init_n | output | 1 | Platform flash init line, held inactive (1) |
| busy | output | 1 | Capture in progress |
| done | output | 1 | One-cycle pulse: samples valid |
| sample_a | output | 14 | Channel A result, signed |
| sample_b | output | 14 | Channel B result, signed |

## Verification
The bench sweeps all sixteen codes on each gain input and checks the word received bit by bit. A swapped nibble order or an LSB-first shift would scramble that word. Samples are produced from the converter equation at swept voltages and at the extreme codes -8192, 8191, 0 and -1, with the idle slots filled with varying ones and zeros. A field window that is off by one slot would either pick up an idle bit or shift the sign bit out. The bench also fires repeated starts and changes the gain inputs in the middle of a capture. A sequencer that restarts or relatches its gains would show a second `done` or a changed word.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GAIN,
    ST_GAP,
    ST_CONV,
    ST_READ
  } seq_state_t;

  // Total bit slots in one read frame.
  function automatic int frame_slots(int lead, int width, int mid, int trail);
    return lead + 2 * width + mid + trail;
  endfunction

  // True when slot index idx lies in [first, first+width).
  function automatic logic slot_in_field(int idx, int first, int width);
    return (idx >= first) && (idx < first + width);
  endfunction

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sck,
  output logic rise_evt,
  output logic fall_evt
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;
  logic          tick;

  assign tick     = run && (cnt == LAST);
  assign rise_evt = tick && !sck;
  assign fall_evt = tick && sck;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      sck <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      sck <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      sck <= ~sck;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/gain_shifter.sv
module gain_shifter #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              shift,
  output logic              mosi
);
  logic [WORD_W-1:0] sreg;

  assign mosi = sreg[WORD_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg <= '0;
    end else if (load) begin
      sreg <= load_word;
    end else if (shift) begin
      sreg <= {sreg[WORD_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/frame_collector.sv
module frame_collector
  import adc_seq_pkg::*;
#(
  parameter int SAMPLE_W  = 14,
  parameter int LEAD_BITS = 2,
  parameter int MID_BITS  = 2,
  parameter int IDX_W     = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clear,
  input  logic                       rise,
  input  logic [IDX_W-1:0]           slot,
  input  logic                       miso,
  input  logic                       commit,
  output logic signed [SAMPLE_W-1:0] sample_a,
  output logic signed [SAMPLE_W-1:0] sample_b
);
  localparam int A_FIRST = LEAD_BITS;
  localparam int B_FIRST = LEAD_BITS + SAMPLE_W + MID_BITS;

  logic [SAMPLE_W-1:0] acc_a, acc_b;
  logic                hit_a, hit_b;

  assign hit_a = rise && slot_in_field(int'(slot), A_FIRST, SAMPLE_W);
  assign hit_b = rise && slot_in_field(int'(slot), B_FIRST, SAMPLE_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_a <= '0;
      acc_b <= '0;
    end else if (clear) begin
      acc_a <= '0;
      acc_b <= '0;
    end else begin
      if (hit_a) acc_a <= {acc_a[SAMPLE_W-2:0], miso};
      if (hit_b) acc_b <= {acc_b[SAMPLE_W-2:0], miso};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample_a <= '0;
      sample_b <= '0;
    end else if (commit) begin
      sample_a <= signed'(acc_a);
      sample_b <= signed'(acc_b);
    end
  end
endmodule

// File: rtl/adc_capture_seq.sv
module adc_capture_seq
  import adc_seq_pkg::*;
#(
  parameter int SAMPLE_W    = 14,
  parameter int GAIN_W      = 4,
  parameter int HALF_DIV    = 4,
  parameter int LEAD_BITS   = 2,
  parameter int MID_BITS    = 2,
  parameter int TRAIL_BITS  = 2,
  parameter int CS_GAP_CLKS = 2,
  parameter int CONV_CLKS   = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [GAIN_W-1:0]          gain_a,
  input  logic [GAIN_W-1:0]          gain_b,
  input  logic                       miso,
  output logic                       sck,
  output logic                       mosi,
  output logic                       amp_cs_n,
  output logic                       adc_conv,
  output logic                       flash_ss_n,
  output logic                       dac_cs_n,
  output logic                       pflash_ce,
  output logic                       prom_init_n,
  output logic                       busy,
  output logic                       done,
  output logic signed [SAMPLE_W-1:0] sample_a,
  output logic signed [SAMPLE_W-1:0] sample_b
);
  localparam int WORD_W     = 2 * GAIN_W;
  localparam int FRAME_BITS = frame_slots(LEAD_BITS, SAMPLE_W, MID_BITS, TRAIL_BITS);
  localparam int IDX_W      = $clog2(max2(FRAME_BITS, WORD_W) + 1);
  localparam int WAIT_W     = $clog2(max2(CS_GAP_CLKS, CONV_CLKS) + 1);
  localparam logic [IDX_W-1:0]  WORD_LAST  = IDX_W'(WORD_W - 1);
  localparam logic [IDX_W-1:0]  FRAME_LAST = IDX_W'(FRAME_BITS - 1);
  localparam logic [WAIT_W-1:0] GAP_LAST   = WAIT_W'(CS_GAP_CLKS - 1);
  localparam logic [WAIT_W-1:0] CONV_LAST  = WAIT_W'(CONV_CLKS - 1);

  seq_state_t        state;
  logic [IDX_W-1:0]  bit_cnt;
  logic [WAIT_W-1:0] wait_cnt;

  // Named internal events (also used by the checker)
  logic gain_phase, read_phase, sck_run;
  logic rise_evt, fall_evt;
  logic accept, gain_end, read_end, gap_end, conv_end;

  assign gain_phase = (state == ST_GAIN);
  assign read_phase = (state == ST_READ);
  assign sck_run    = gain_phase || read_phase;
  assign accept     = (state == ST_IDLE) && start;
  assign gain_end   = gain_phase && fall_evt && (bit_cnt == WORD_LAST);
  assign read_end   = read_phase && fall_evt && (bit_cnt == FRAME_LAST);
  assign gap_end    = (state == ST_GAP) && (wait_cnt == GAP_LAST);
  assign conv_end   = (state == ST_CONV) && (wait_cnt == CONV_LAST);

  // Other devices on the shared bus stay at their inactive levels.
  assign flash_ss_n  = 1'b1;
  assign dac_cs_n    = 1'b1;
  assign pflash_ce   = 1'b1;
  assign prom_init_n = 1'b1;

  assign amp_cs_n = !gain_phase;
  assign adc_conv = (state == ST_CONV);
  assign busy     = (state != ST_IDLE);

  spi_clk_div #(.HALF_DIV(HALF_DIV)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (sck_run),
    .sck      (sck),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  gain_shifter #(.WORD_W(WORD_W)) u_gain (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .load_word ({gain_b, gain_a}),
    .shift     (gain_phase && fall_evt),
    .mosi      (mosi)
  );

  frame_collector #(
    .SAMPLE_W  (SAMPLE_W),
    .LEAD_BITS (LEAD_BITS),
    .MID_BITS  (MID_BITS),
    .IDX_W     (IDX_W)
  ) u_coll (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (conv_end),
    .rise     (read_phase && rise_evt),
    .slot     (bit_cnt),
    .miso     (miso),
    .commit   (read_end),
    .sample_a (sample_a),
    .sample_b (sample_b)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      wait_cnt <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state   <= ST_GAIN;
            bit_cnt <= '0;
          end
        end
        ST_GAIN: begin
          if (gain_end) begin
            state    <= ST_GAP;
            wait_cnt <= '0;
          end else if (fall_evt) begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
        ST_GAP: begin
          if (gap_end) begin
            state    <= ST_CONV;
            wait_cnt <= '0;
          end else begin
            wait_cnt <= wait_cnt + 1'b1;
          end
        end
        ST_CONV: begin
          if (conv_end) begin
            state   <= ST_READ;
            bit_cnt <= '0;
          end else begin
            wait_cnt <= wait_cnt + 1'b1;
          end
        end
        ST_READ: begin
          if (read_end) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else if (fall_evt) begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_capture_seq_checker.sv
module adc_capture_seq_checker #(
  parameter int SAMPLE_W = 14
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start,
  input logic                sck,
  input logic                amp_cs_n,
  input logic                adc_conv,
  input logic                busy,
  input logic                done,
  input logic                gain_phase,
  input logic                read_phase,
  input logic [SAMPLE_W-1:0] sample_a,
  input logic [SAMPLE_W-1:0] sample_b
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sck && amp_cs_n && !adc_conv)); // R1

  AST_SCK_IN_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> (gain_phase || read_phase)); // R3

  AST_AMP_CONV_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !amp_cs_n |-> !adc_conv); // R4

  AST_CONV_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    adc_conv |-> (!sck && amp_cs_n)); // R4

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6

  AST_SAMPLES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(sample_a) && $stable(sample_b))); // R6

  AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R7
endmodule

bind adc_capture_seq adc_capture_seq_checker #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .sck        (sck),
  .amp_cs_n   (amp_cs_n),
  .adc_conv   (adc_conv),
  .busy       (busy),
  .done       (done),
  .gain_phase (gain_phase),
  .read_phase (read_phase),
  .sample_a   (sample_a),
  .sample_b   (sample_b)
);

// File: tb/test_adc_capture_seq.sv
`timescale 1ns/1ps
module test_adc_capture_seq;
  localparam int HALF  = 2;
  localparam int GAP   = 2;
  localparam int CONV  = 3;
  localparam int SW    = 14;
  localparam int FRAME = 34;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [3:0] gain_a = '0, gain_b = '0;
  logic miso = 1'b0;
  logic sck, mosi, amp_cs_n, adc_conv, flash_ss_n, dac_cs_n, pflash_ce, prom_init_n;
  logic busy, done;
  logic signed [SW-1:0] sample_a, sample_b;

  always #2.5 clk = ~clk;

  adc_capture_seq #(.HALF_DIV(HALF), .CS_GAP_CLKS(GAP), .CONV_CLKS(CONV)) i_adc_capture_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .gain_a(gain_a), .gain_b(gain_b),
    .miso(miso), .sck(sck), .mosi(mosi), .amp_cs_n(amp_cs_n), .adc_conv(adc_conv),
    .flash_ss_n(flash_ss_n), .dac_cs_n(dac_cs_n), .pflash_ce(pflash_ce),
    .prom_init_n(prom_init_n), .busy(busy), .done(done),
    .sample_a(sample_a), .sample_b(sample_b)
  );

  int n_vec = 0, n_bad = 0;
  int cyc = 0;

  // Bench-side device model / monitor state
  logic [FRAME-1:0] frame = '0;
  logic [7:0] gword;
  int grises, rrises, ridx, conv_len, dones, idle_err, per_err;
  int amp_rise_cyc, conv_rise_cyc, last_rise;
  bit reading = 0, have_rise = 0;
  logic p_sck = 0, p_amp = 1, p_conv = 0;
  logic signed [SW-1:0] got_a, got_b;

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) if (cyc > 150000) begin
    n_bad++;
    $display("FAIL watchdog: actual cycle %0d expected < 150000", cyc);
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (!flash_ss_n || !dac_cs_n || !pflash_ce || !prom_init_n) idle_err++;
      if (adc_conv || !busy) have_rise = 0;
      if (sck && !p_sck) begin
        if (have_rise && (cyc - last_rise) != 2*HALF) per_err++;
        have_rise = 1;
        last_rise = cyc;
        if (!amp_cs_n) begin gword = {gword[6:0], mosi}; grises++; end
        if (reading) rrises++;
      end
      if (!sck && p_sck && reading) begin
        ridx++;
        if (ridx < FRAME) miso = frame[FRAME-1-ridx];
      end
      if (adc_conv) begin
        conv_len++;
        if (!p_conv) begin
          reading = 1; ridx = 0; miso = frame[FRAME-1]; conv_rise_cyc = cyc;
        end
      end
      if (amp_cs_n && !p_amp) amp_rise_cyc = cyc;
      if (done) begin dones++; got_a = sample_a; got_b = sample_b; reading = 0; end
      p_sck = sck; p_amp = amp_cs_n; p_conv = adc_conv;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Converter equation used to produce stimulus codes
  function automatic int gain_of(int code);
    case (code)
      1: return -1;  2: return -2;  3: return -5;   4: return -10;
      5: return -20; 6: return -50; 7: return -100; default: return 0;
    endcase
  endfunction

  function automatic logic signed [SW-1:0] conv_code(int code, int mv);
    longint v;
    v = longint'(gain_of(code)) * (mv - 1650) * 8192 / 1250;
    if (v > 8191) v = 8191;
    if (v < -8192) v = -8192;
    return SW'(v);
  endfunction

  task automatic capture(input logic [3:0] ga, input logic [3:0] gb,
                         input logic signed [SW-1:0] sa, input logic signed [SW-1:0] sb,
                         input logic [1:0] idl, input bit disturb);
    int t;
    frame = {idl, sa, ~idl, sb, idl ^ 2'b01};   // R5: idle slots carry junk
    gword = '0; grises = 0; rrises = 0; conv_len = 0; dones = 0;
    idle_err = 0; per_err = 0;
    @(negedge clk);
    gain_a = ga; gain_b = gb; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R7 busy after start", busy, 1);
    if (disturb) begin
      gain_a = ~ga; gain_b = ~gb;               // R9: late gain change
      for (int k = 0; k < 12; k++) begin
        repeat (9) @(negedge clk);
        start = 1'b1; @(negedge clk); start = 1'b0;
      end
    end
    t = 0;
    while (dones == 0 && t < 3000) begin @(negedge clk); t++; end
    check(busy === 1'b0, "R7 busy low with done", busy, 0);
    repeat (disturb ? 400 : 20) @(negedge clk);
    check(gword == {gb, ga}, "R3/R9 gain word", gword, {gb, ga});
    check(grises == 8, "R3 gain sck edges", grises, 8);
    check(conv_len == CONV, "R4 conv width", conv_len, CONV);
    check(conv_rise_cyc - amp_rise_cyc == GAP, "R4 cs-to-conv gap",
          conv_rise_cyc - amp_rise_cyc, GAP);
    check(rrises == FRAME, "R5 read sck edges", rrises, FRAME);
    check(got_a == sa, "R5 sample_a", got_a, sa);
    check(got_b == sb, "R5 sample_b", got_b, sb);
    check(dones == 1, "R6/R7 done count", dones, 1);
    check(sample_a == sa && sample_b == sb, "R6 samples held", sample_a, sa);
    check(per_err == 0, "R8 sck period", per_err, 0);
    check(idle_err == 0, "R2 other selects inactive", idle_err, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    check(sck === 1'b0 && amp_cs_n === 1'b1 && adc_conv === 1'b0, "R1 bus idle in reset",
          {sck, amp_cs_n, adc_conv}, 3'b010);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0, "R1 busy/done idle", {busy, done}, 0);
    check(sample_a == 0 && sample_b == 0, "R1 samples zero", sample_a, 0);
    check(flash_ss_n && dac_cs_n && pflash_ce && prom_init_n, "R2 idle levels",
          {flash_ss_n, dac_cs_n, pflash_ce, prom_init_n}, 15);

    // Sweep all gain codes on both channels with equation-derived samples
    for (int i = 0; i < 16; i++) begin
      capture(4'(i), 4'(15 - i),
              conv_code(i % 8, 400 + i * 160),
              conv_code(7 - (i % 8), 2900 - i * 150),
              2'(i), 1'b0);
    end
    // Extreme codes
    capture(4'h1, 4'h7, -14'sd8192, 14'sd8191, 2'b11, 1'b0);
    capture(4'h7, 4'h1, 14'sd8191, -14'sd8192, 2'b00, 1'b0);
    capture(4'h3, 4'hC, 14'sd0, -14'sd1, 2'b10, 1'b0);
    capture(4'hA, 4'h5, 14'sh1555, 14'sh2AAA, 2'b01, 1'b0);
    // R7/R9: starts and gain changes while busy
    capture(4'h9, 4'h6, 14'sh0F0F, -14'sd100, 2'b11, 1'b1);

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule